// File: doc/BRIEF.md
# Polled Entropy Data Register

This block gives software a polled source of random words. It holds one 32-bit word that an entropy distribution network supplies, together with a flag that says whether the word is still unused. Software reads the flag through a status offset. When the flag is set, software reads the word through a data offset. Reading the word uses it up. The flag clears and a fresh fetch toward the entropy provider starts at once. Software then polls the status again until the next word arrives.

The block talks to the provider over a level request / acknowledge pair. The request stays high until the provider acknowledges, and the acknowledged word is captured on that edge. The block is built so that at every moment exactly one of two things holds: it has a valid word, or it has a request outstanding. It is never idle without data. Out of reset it has no data and asks for a word immediately. That request may wait for as long as the provider takes to answer.

Top module: `rnd_poll_reg`

## Requirements
- R1: After reset the word is invalid, `ent_req` is 1 and a status read returns 0.
- R2: While no acknowledge arrives, `ent_req` stays at 1 on every cycle.
- R3: An acknowledge while `ent_req` is 1 captures `ent_word` on that edge. From the next cycle the word is valid and `ent_req` is 0.
- R4: A read at the data offset (`rd_addr` = 0) while the word is valid returns the stored word in the same cycle. From the next cycle the word is invalid and `ent_req` is 1.
- R5: A read at the data offset while the word is invalid returns 0 and leaves the request and the validity unchanged.
- R6: A read at the status offset (`rd_addr` = 1) returns the valid flag in bit 0 and 0 in bits 31:1. It has no side effect.
- R7: On every cycle after reset, exactly one of "word valid" and `ent_req` is true.
- R8: A read at any other offset returns 0 and has no side effect.
- R9: An acknowledge that arrives while no request is outstanding is ignored, and the stored word is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Register read strobe, one cycle per read |
| rd_addr | input | ADDR_W (2) | Word offset of the read |
| rd_data | output | DATA_W (32) | Read data, valid in the cycle of `rd_en` |
| ent_req | output | 1 | Request toward the entropy provider |
| ent_ack | input | 1 | Provider acknowledge, returns one word |
| ent_word | input | DATA_W (32) | Word returned with the acknowledge |

## Verification
The bench reads the data offset while no word is held. A design that treated this read as a consume would drop or re-raise its request at the wrong time, or return a stale word instead of zero. It drives an acknowledge in the same cycle as such an invalid read, and a design that gated the capture on the read would lose the word. It also drives a stray acknowledge while a word is held, which catches a design that overwrites unused entropy. Back-to-back fill and consume rounds with all-zero and all-one words check that the returned value is the captured one and that the valid flag and the request always swap together.

// File: rtl/rnd_poll_pkg.sv
package rnd_poll_pkg;

  // Two-state fill tracker: either waiting on the provider or holding a word.
  typedef enum logic {
    FILL_WAIT = 1'b0,
    FILL_FULL = 1'b1
  } fill_state_e;

endpackage

// File: rtl/rnd_fetch_ctrl.sv
module rnd_fetch_ctrl
  import rnd_poll_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ack_i,
  input  logic consume_i,
  output logic req_o,
  output logic valid_o,
  output logic load_o
);

  fill_state_e state_q, state_d;

  // next-state logic
  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    unique case (state_q)
      FILL_WAIT: begin
        if (ack_i) begin
          state_d = FILL_FULL;
          load_o  = 1'b1;
        end
      end
      FILL_FULL: begin
        if (consume_i) begin
          state_d = FILL_WAIT;
        end
      end
      default: state_d = FILL_WAIT;
    endcase
  end

  // state register; reset leaves the block asking for data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FILL_WAIT;
    end else begin
      state_q <= state_d;
    end
  end

  assign req_o   = (state_q == FILL_WAIT);
  assign valid_o = (state_q == FILL_FULL);

endmodule

// File: rtl/rnd_word_hold.sv
module rnd_word_hold #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] word_o
);

  logic [DATA_W-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (load_i) begin
      word_d = word_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else begin
      word_q <= word_d;
    end
  end

  assign word_o = word_q;

endmodule

// File: rtl/rnd_read_mux.sv
module rnd_read_mux #(
  parameter int                DATA_W     = 32,
  parameter int                ADDR_W     = 2,
  parameter logic [ADDR_W-1:0] DATA_OFS   = '0,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 1
) (
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              consume_o
);

  logic hit_data, hit_status;

  assign hit_data   = rd_en_i && (rd_addr_i == DATA_OFS);
  assign hit_status = rd_en_i && (rd_addr_i == STATUS_OFS);

  always_comb begin
    rd_data_o = '0;
    if (hit_data && valid_i) begin
      rd_data_o = word_i;
    end else if (hit_status) begin
      rd_data_o[0] = valid_i;
    end
  end

  // only a read that actually returns a word uses it up
  assign consume_o = hit_data && valid_i;

endmodule

// File: rtl/rnd_poll_reg.sv
module rnd_poll_reg #(
  parameter int                DATA_W     = 32,
  parameter int                ADDR_W     = 2,
  parameter logic [ADDR_W-1:0] DATA_OFS   = '0,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              ent_req,
  input  logic              ent_ack,
  input  logic [DATA_W-1:0] ent_word
);

  logic              fill_valid;
  logic              fill_load;
  logic              consume;
  logic [DATA_W-1:0] held_word;

  rnd_fetch_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_i     (ent_ack),
    .consume_i (consume),
    .req_o     (ent_req),
    .valid_o   (fill_valid),
    .load_o    (fill_load)
  );

  rnd_word_hold #(.DATA_W(DATA_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (fill_load),
    .word_i (ent_word),
    .word_o (held_word)
  );

  rnd_read_mux #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .DATA_OFS   (DATA_OFS),
    .STATUS_OFS (STATUS_OFS)
  ) u_mux (
    .rd_en_i   (rd_en),
    .rd_addr_i (rd_addr),
    .valid_i   (fill_valid),
    .word_i    (held_word),
    .rd_data_o (rd_data),
    .consume_o (consume)
  );

endmodule

// File: rtl/rnd_poll_reg_chk.sv
module rnd_poll_reg_chk #(
  parameter int                DATA_W     = 32,
  parameter int                ADDR_W     = 2,
  parameter logic [ADDR_W-1:0] DATA_OFS   = '0,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              ent_req,
  input logic              ent_ack,
  input logic [DATA_W-1:0] ent_word,
  input logic              valid,
  input logic [DATA_W-1:0] word
);

  logic rd_dat, rd_sts, rd_other;
  assign rd_dat   = rd_en && (rd_addr == DATA_OFS);
  assign rd_sts   = rd_en && (rd_addr == STATUS_OFS);
  assign rd_other = rd_en && !rd_dat && !rd_sts;

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_req && !ent_ack) |=> ent_req);

  p_ack_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_req && ent_ack) |=> (valid && !ent_req && word == $past(ent_word)));

  p_consume_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dat && valid) |-> (rd_data == word) ##1 (!valid && ent_req));

  p_invalid_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dat && !valid) |-> (rd_data == '0));

  p_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sts |-> (rd_data == {{(DATA_W-1){1'b0}}, valid}));

  p_status_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sts && !ent_ack) |=> $stable(valid));

  p_one_of_two_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid != ent_req));

  p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_other |-> (rd_data == '0));

  p_stray_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ent_ack) |=> (word == $past(word)));

endmodule

bind rnd_poll_reg rnd_poll_reg_chk #(
  .DATA_W     (DATA_W),
  .ADDR_W     (ADDR_W),
  .DATA_OFS   (DATA_OFS),
  .STATUS_OFS (STATUS_OFS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data),
  .ent_req  (ent_req),
  .ent_ack  (ent_ack),
  .ent_word (ent_word),
  .valid    (fill_valid),
  .word     (held_word)
);

// File: tb/rnd_poll_reg_tb.sv
module rnd_poll_reg_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;

  logic        clk;
  logic        rst_n;
  logic        rd_en;
  logic [1:0]  rd_addr;
  logic [31:0] rd_data;
  logic        ent_req;
  logic        ent_ack;
  logic [31:0] ent_word;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  rnd_poll_reg u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .ent_req  (ent_req),
    .ent_ack  (ent_ack),
    .ent_word (ent_word)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive a one-cycle read at a falling edge, sample, release at the next falling edge
  task automatic do_read(input logic [1:0] addr, output logic [31:0] val);
    rd_en   = 1'b1;
    rd_addr = addr;
    #1 val  = rd_data;
    @(negedge clk);
    rd_en   = 1'b0;
    rd_addr = 2'd0;
  endtask

  task automatic give_ack(input logic [31:0] w);
    ent_ack  = 1'b1;
    ent_word = w;
    @(negedge clk);
    ent_ack  = 1'b0;
    ent_word = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 req after reset", {31'b0, ent_req}, 32'd1);
    do_read(A_STAT, v);
    check("R1 status after reset", v, 32'd0);
  endtask

  task automatic t_wait_hold();
    logic [31:0] v;
    repeat (6) @(negedge clk);
    check("R2 req held without ack", {31'b0, ent_req}, 32'd1);
    do_read(A_DATA, v);
    check("R5 invalid data read value", v, 32'd0);
    check("R5 req unchanged after invalid read", {31'b0, ent_req}, 32'd1);
    do_read(A_STAT, v);
    check("R5 still invalid after invalid read", v, 32'd0);
  endtask

  task automatic t_fill_consume(input logic [31:0] w);
    logic [31:0] v;
    give_ack(w);
    check("R3 req drops after ack", {31'b0, ent_req}, 32'd0);
    do_read(A_STAT, v);
    check("R6 status shows valid", v, 32'd1);
    do_read(A_STAT, v);
    check("R6 status read has no side effect", v, 32'd1);
    check("R7 no request while valid", {31'b0, ent_req}, 32'd0);
    do_read(A_DATA, v);
    check("R4 consumed word value", v, w);
    check("R4 request after consume", {31'b0, ent_req}, 32'd1);
    do_read(A_STAT, v);
    check("R7 invalid while requesting", v, 32'd0);
    do_read(A_DATA, v);
    check("R5 second read returns zero", v, 32'd0);
  endtask

  task automatic t_stray_and_unmapped();
    logic [31:0] v;
    give_ack(32'hA5A5_0F0F);
    give_ack(32'h1234_5678);
    check("R9 req stays low after stray ack", {31'b0, ent_req}, 32'd0);
    do_read(2'd2, v);
    check("R8 offset 2 reads zero", v, 32'd0);
    do_read(2'd3, v);
    check("R8 offset 3 reads zero", v, 32'd0);
    do_read(A_STAT, v);
    check("R8 word still valid after unmapped reads", v, 32'd1);
    do_read(A_DATA, v);
    check("R9 stray ack ignored", v, 32'hA5A5_0F0F);
  endtask

  task automatic t_ack_with_invalid_read();
    logic [31:0] v;
    ent_ack  = 1'b1;
    ent_word = 32'hC0DE_0001;
    rd_en    = 1'b1;
    rd_addr  = A_DATA;
    #1 v = rd_data;
    check("R5 read in ack cycle returns zero", v, 32'd0);
    @(negedge clk);
    ent_ack = 1'b0;
    rd_en   = 1'b0;
    check("R3 ack captured despite invalid read", {31'b0, ent_req}, 32'd0);
    do_read(A_DATA, v);
    check("R3 word from ack cycle", v, 32'hC0DE_0001);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    rst_n    = 1'b0;
    rd_en    = 1'b0;
    rd_addr  = '0;
    ent_ack  = 1'b0;
    ent_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wait_hold();
    t_fill_consume(32'hDEAD_BEEF);
    t_fill_consume(32'h0000_0000);
    t_fill_consume(32'hFFFF_FFFF);
    t_stray_and_unmapped();
    t_ack_with_invalid_read();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

endmodule